// File: doc/BRIEF.md
# Two-Wire Serial I/O Transmitter

This block sends processor-to-peripheral transfers over a four-line bus: a bus clock, two data lines and an active-low direction line. It runs on a repeating four-phase cycle, with one system clock cycle per phase. It reports the current phase index on `phase`, where 0 to 3 stand for phases 1 to 4.

A caller presents a transfer kind and a 16-bit word with a one-cycle `req_valid` strobe. The block holds one request until the next phase 4 in which it is idle. It then frames the transfer on the bus and raises `busy` for as long as the direction line is low.

Short kinds send only a code slot. Long kinds send a code slot and then the word, two bits at a time, one bit on each data line.

Top module: `sio_tx`

## Requirements
- R1: After reset, `bus_clk`, `bus_d1`, `bus_d2` and `bus_dir_n` are all high, `busy` is low and `phase` is 0.
- R2: Every transfer drives `bus_dir_n` low in a phase 4 (`phase`==3). `bus_clk` goes low in the following phase 1 and high in the phase 2 after that.
- R3: Kind 0 (enable code) drives both data lines high in its one clock-low interval. `bus_dir_n` returns high in the following phase 3, so the line is low for exactly three phases.
- R4: Kind 1 (acknowledge code) drives `bus_d1` high and `bus_d2` low in its one clock-low interval. It has the same length as kind 0.
- R5: Kinds 2 (command) and 3 (data-out) produce five `bus_clk` low pulses. Each pulse is low in a phase 1 or phase 3 and high in the phase after it.
- R6: In the first clock-low interval of a long kind, the data lines carry the kind code. Kind 2 puts `bus_d1`=0 and `bus_d2`=0. Kind 3 puts `bus_d1`=0 and `bus_d2`=1.
- R7: In the eight phases that follow the code slot, phase k (k=0..7) carries word bit k on `bus_d1` and word bit 8+k on `bus_d2`. A high level means 1.
- R8: In a long kind, both data lines are high in the phase after the eighth data phase. `bus_dir_n` returns high in the phase 3 after the fifth clock rise, so the line is low for eleven phases.
- R9: `busy` is high exactly in the phases in which `bus_dir_n` is low.
- R10: A request accepted while a transfer is in progress is held. It starts in the phase 4 that directly follows the phase in which `bus_dir_n` returns high, and it carries its own kind and word.
- R11: A request presented while another request is already held is dropped. It has no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one phase per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_kind | input | 2 | Transfer kind: 0 enable, 1 acknowledge, 2 command, 3 data-out |
| req_word | input | 16 | Word sent by the long kinds |
| busy | output | 1 | High while a transfer holds the bus |
| phase | output | 2 | Current phase index, 0..3 for phases 1..4 |
| bus_clk | output | 1 | Bus clock line |
| bus_d1 | output | 1 | Data line 1 |
| bus_d2 | output | 1 | Data line 2 |
| bus_dir_n | output | 1 | Direction line, low during a transfer |

## Verification
The bench compares every phase of every transfer against a waveform computed from the kind and the word. It sweeps all four kinds, and it runs walking-one and walking-zero words through both long kinds.

Swapped lanes or a reversed bit order would show up as misplaced ones. A wrong code-slot encoding would garble the first clock-low interval. A transfer that ends one phase early or late would give the wrong direction-line length and the wrong return phase.

A request queued behind a long transfer checks that the held word is not lost and that its start comes exactly two phases after the previous end. A request overlapping a held one checks that nothing extra reaches the bus.

// File: rtl/sio_tx_pkg.sv
package sio_tx_pkg;

    localparam int WORD_W    = 16;
    localparam int LANE_W    = WORD_W / 2;
    localparam int SHORT_END = 2;
    localparam int LONG_END  = LANE_W + 2;
    localparam int STEP_W    = $clog2(LONG_END + 1);

    typedef enum logic [1:0] {
        K_ENABLE = 2'd0,
        K_ACK    = 2'd1,
        K_CMD    = 2'd2,
        K_DOUT   = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [WORD_W-1:0] word;
    } xfer_t;

    typedef struct packed {
        logic clk;
        logic d1;
        logic d2;
        logic dir_n;
    } lines_t;

    function automatic logic is_long(kind_e k);
        return (k == K_CMD) || (k == K_DOUT);
    endfunction

    function automatic logic [1:0] slot_code(kind_e k);
        case (k)
            K_ENABLE: return 2'b11;
            K_ACK:    return 2'b10;
            K_CMD:    return 2'b00;
            default:  return 2'b01;
        endcase
    endfunction

endpackage

// File: rtl/sio_phase_ctr.sv
module sio_phase_ctr (
    input  logic       clk,
    input  logic       rst,
    output logic [1:0] ph
);
    always_ff @(posedge clk) begin
        if (rst) ph <= 2'd0;
        else     ph <= ph + 2'd1;
    end
endmodule

// File: rtl/sio_seq.sv
module sio_seq
    import sio_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        ph,
    input  logic              req_valid,
    input  xfer_t             req,
    output logic              active,
    output logic [STEP_W-1:0] step,
    output xfer_t             cur
);
    logic  pend_v;
    xfer_t pend;
    logic  launch;
    logic  last_step;

    assign launch    = pend_v && !active && (ph == 2'd2);
    assign last_step = is_long(cur.kind) ? (step == STEP_W'(LONG_END))
                                         : (step == STEP_W'(SHORT_END));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend   <= '0;
            active <= 1'b0;
            step   <= '0;
            cur    <= '0;
        end else begin
            if (req_valid && (!pend_v || launch)) pend <= req;
            pend_v <= launch ? req_valid : (pend_v || req_valid);
            if (launch) begin
                active <= 1'b1;
                step   <= '0;
                cur    <= pend;
            end else if (active) begin
                step <= step + 1'b1;
                if (last_step) active <= 1'b0;
            end
        end
    end

    AST_START_IN_PH4: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> (ph == 2'd3)); // R2
    AST_END_IN_PH3: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> (ph == 2'd2)); // R8
endmodule

// File: rtl/sio_line_enc.sv
module sio_line_enc
    import sio_tx_pkg::*;
(
    input  logic              active,
    input  logic [STEP_W-1:0] step,
    input  xfer_t             cur,
    output lines_t            lines
);
    logic [1:0] slot;
    int         bit_idx;

    always_comb begin
        slot        = slot_code(cur.kind);
        bit_idx     = int'(step) - 2;
        lines.dir_n = !active;
        lines.clk   = !(active && step[0] && (step <= STEP_W'(LONG_END - 1)));
        lines.d1    = 1'b1;
        lines.d2    = 1'b1;
        if (active && step == STEP_W'(1)) begin
            lines.d1 = slot[1];
            lines.d2 = slot[0];
        end else if (active && is_long(cur.kind) && step >= STEP_W'(2)
                     && step <= STEP_W'(LONG_END - 1)) begin
            lines.d1 = cur.word[bit_idx[$clog2(LANE_W)-1:0]];
            lines.d2 = cur.word[LANE_W + bit_idx[$clog2(LANE_W)-1:0]];
        end
    end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [WORD_W-1:0] req_word,
    output logic              busy,
    output logic [1:0]        phase,
    output logic              bus_clk,
    output logic              bus_d1,
    output logic              bus_d2,
    output logic              bus_dir_n
);
    logic              active;
    logic [STEP_W-1:0] step;
    xfer_t             cur;
    xfer_t             req;
    lines_t            lines;

    assign req = '{kind: kind_e'(req_kind), word: req_word};

    sio_phase_ctr u_ph (.clk(clk), .rst(rst), .ph(phase));

    sio_seq u_seq (
        .clk(clk), .rst(rst), .ph(phase), .req_valid(req_valid), .req(req),
        .active(active), .step(step), .cur(cur)
    );

    sio_line_enc u_enc (.active(active), .step(step), .cur(cur), .lines(lines));

    assign busy      = active;
    assign bus_clk   = lines.clk;
    assign bus_d1    = lines.d1;
    assign bus_d2    = lines.d2;
    assign bus_dir_n = lines.dir_n;

    AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (rst)
        bus_dir_n |-> (bus_clk && bus_d1 && bus_d2)); // R1
    AST_CLK_FALL_ODD_PHASE: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_clk) |-> (phase == 2'd0 || phase == 2'd2)); // R5
    AST_CLK_LOW_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
        !bus_clk |=> bus_clk); // R5
    AST_BUSY_TRACKS_DIR: assert property (@(posedge clk) disable iff (rst)
        busy == !bus_dir_n); // R9
endmodule

// File: tb/sim_sio_tx.sv
module sim_sio_tx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_word = 16'd0;
    logic        busy, bus_clk, bus_d1, bus_d2, bus_dir_n;
    logic [1:0]  phase;
    int          n_chk = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    sio_tx u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_word(req_word), .busy(busy), .phase(phase), .bus_clk(bus_clk),
        .bus_d1(bus_d1), .bus_d2(bus_d2), .bus_dir_n(bus_dir_n)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(logic [1:0] k, logic [15:0] w);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_word = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_start();
        for (int i = 0; i < 12; i++) begin
            if (!bus_dir_n) break;
            @(negedge clk);
        end
    endtask

    // On entry: the negedge of the first phase with bus_dir_n low.
    // On exit: the negedge of the first phase with bus_dir_n high again.
    task automatic check_wave(logic [1:0] k, logic [15:0] w);
        int  last;
        logic ec, e1, e2;
        last = (k >= 2) ? 10 : 2;
        chk("R2 start phase", {30'd0, phase}, 32'd3);
        for (int s = 0; s <= last; s++) begin
            ec = !((s % 2 == 1) && s <= 9);
            e1 = 1'b1; e2 = 1'b1;
            if (s == 1) begin
                case (k)
                    2'd0: begin e1 = 1; e2 = 1; end
                    2'd1: begin e1 = 1; e2 = 0; end
                    2'd2: begin e1 = 0; e2 = 0; end
                    default: begin e1 = 0; e2 = 1; end
                endcase
            end else if (k >= 2 && s >= 2 && s <= 9) begin
                e1 = w[s-2];
                e2 = w[s+6];
            end
            if (s == 1 && k < 2)
                chk(k == 0 ? "R3 enable slot" : "R4 ack slot",
                    {27'd0, bus_dir_n, bus_clk, bus_d1, bus_d2, busy},
                    {27'd0, 1'b0, ec, e1, e2, 1'b1});
            else if (s == 1)
                chk("R6 code slot", {27'd0, bus_dir_n, bus_clk, bus_d1, bus_d2, busy},
                    {27'd0, 1'b0, ec, e1, e2, 1'b1});
            else if (k >= 2)
                chk("R5 R7 R9 long phase", {27'd0, bus_dir_n, bus_clk, bus_d1, bus_d2, busy},
                    {27'd0, 1'b0, ec, e1, e2, 1'b1});
            else
                chk("R2 R9 short phase", {27'd0, bus_dir_n, bus_clk, bus_d1, bus_d2, busy},
                    {27'd0, 1'b0, ec, e1, e2, 1'b1});
            @(negedge clk);
        end
        chk(k >= 2 ? "R8 end" : "R3 end",
            {28'd0, bus_dir_n, busy, phase}, {28'd0, 1'b1, 1'b0, 2'd2});
    endtask

    initial begin : wd
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset lines", {26'd0, bus_clk, bus_d1, bus_d2, bus_dir_n, busy, 1'b0},
            {26'd0, 4'b1111, 1'b0, 1'b0});
        chk("R1 reset phase", {30'd0, phase}, 32'd0);

        for (int k = 0; k < 2; k++) begin
            send(2'(k), 16'hFFFF);
            wait_start();
            check_wave(2'(k), 16'hFFFF);
        end

        for (int k = 2; k < 4; k++) begin
            for (int b = 0; b < 16; b++) begin
                w = 16'(1) << b;
                send(2'(k), w);
                wait_start();
                check_wave(2'(k), w);
                send(2'(k), ~w);
                wait_start();
                check_wave(2'(k), ~w);
            end
            send(2'(k), 16'hA5C3);
            wait_start();
            check_wave(2'(k), 16'hA5C3);
        end

        // R10: queue behind a long transfer; R11: overlap dropped
        send(2'd3, 16'h1234);
        wait_start();
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd2; req_word = 16'h8E71;
        @(negedge clk);
        req_kind = 2'd0; req_word = 16'h0000;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (bus_dir_n) break;
            @(negedge clk);
        end
        chk("R10 gap phase", {30'd0, phase}, 32'd2);
        @(negedge clk);
        chk("R10 back-to-back start", {31'd0, bus_dir_n}, 32'd0);
        check_wave(2'd2, 16'h8E71);
        for (int i = 0; i < 12; i++) begin
            chk("R11 dropped request idle", {30'd0, bus_dir_n, busy}, {30'd0, 1'b1, 1'b0});
            @(negedge clk);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule